// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps wall-clock time and a calendar in packed BCD. A free-running input clock is divided by `DIV` (32768 by default, for a 32.768 kHz source) into a one-second tick. Each tick advances the seconds register. Carries then ripple through minutes, hours, date, month and year. A separate day-of-week register counts alongside the date. The block handles short months and leap-year Februaries, and the year rolls from 99 to 00 into 2000, which is treated as a leap year.

A host reaches the block through a small register port: a write strobe, a 3-bit address, write data, a snapshot strobe and read data. The field addresses are 0 seconds, 1 minutes, 2 hours, 3 date, 4 day of week, 5 month and 6 year. Address 7 is unused.

Reads come from a snapshot bank. Pulsing `snap_req` copies all seven live fields on one clock edge, so a read can never show a torn value. Writes do not touch the live time. They go into a staging bank and restart the prescaler. The staged set then becomes live at the tick that closes a fresh full second.

A two-state controller sequences the load:
- `ST_RUN` is the normal counting state. It moves to `ST_STAGED` on any write to a valid address.
- `ST_STAGED` holds a pending load. A further write stays in `ST_STAGED`. On a tick it copies the staged set into the live registers and returns to `ST_RUN`.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the live and snapshot fields read seconds 00, minutes 00, hours 00, date 01, day of week 00, month 01, year 00, with the prescaler at zero.
- R2: In `ST_RUN` the seconds field advances by one BCD step on every `DIV`-th clock. Every digit stays within 0 to 9.
- R3: Seconds and minutes wrap 59→00 and carry. Hours run 00–23 and wrap to 00, carrying into the date and day of week.
- R4: Day of week counts 00 to 06 and wraps to 00 on each day carry, independently of the date.
- R5: Months 04, 06, 09 and 11 end after day 30. Months 01, 03, 05, 07, 08, 10 and 12 end after day 31. After the last day, the date returns to 01 and the month advances.
- R6: February ends after day 28, or after day 29 when the BCD year is divisible by four (year 00 included).
- R7: Month 12 wraps to 01 and increments the year. Year 99 wraps to 00.
- R8: A `snap_req` pulse captures all seven live fields on the same edge. `rd_data` shows the snapshot field at `addr`, and the snapshot holds until the next `snap_req`.
- R9: A write to address 0–6 stores into a staging bank and clears the prescaler, and the live time stays as it was. If no later write occurs, the staged set becomes live `DIV` clocks after the write edge. Fields that were not written take the live value held at the first write of the batch.
- R10: A write to address 7 changes no state and does not restart the prescaler. Reading address 7 returns 00.
- R11: Holding or repeating `snap_req` never delays or drops a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock, divided by DIV to one second |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | 3 | Field address for read and write |
| wr_data | input | 8 | BCD value to stage |
| snap_req | input | 1 | Capture the live time into the snapshot bank |
| rd_data | output | 8 | Snapshot field at addr |

## Verification
The range assertions on date, day of week and BCD digits assume the host only writes valid BCD values. They also assume each staged set is a consistent calendar date, for example never day 31 in a 30-day month. The stimulus loads only such sets, always writing all seven fields or only the seconds field. The bench shrinks `DIV` to 4 so that the month-end, leap-year and century rollovers are reached by loading a time one second before each boundary. Timing-sensitive cases sample the snapshot at cycles counted from the write edge.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int NUM_FIELDS = 7;
    localparam int ADDR_W     = $clog2(NUM_FIELDS + 1);

    localparam int IX_SEC  = 0;
    localparam int IX_MIN  = 1;
    localparam int IX_HOUR = 2;
    localparam int IX_DATE = 3;
    localparam int IX_DOW  = 4;
    localparam int IX_MON  = 5;
    localparam int IX_YEAR = 6;

    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_STAGED = 1'b1
    } rtc_state_e;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // tens digit parity plus units digit decides divisibility by four
    function automatic logic is_leap(input logic [7:0] yr);
        logic [3:0] u;
        u = yr[3:0];
        if (yr[4]) return (u == 4'd2) || (u == 4'd6);
        return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST) && !clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clr || tick)    cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R2
    AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/rtc_field.sv
module rtc_field
    import rtc_cal_pkg::*;
#(
    parameter logic [7:0] RST_VAL = 8'h00,
    parameter logic [7:0] MIN_VAL = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  logic       ld,
    input  logic [7:0] ld_val,
    input  logic [7:0] max_val,
    output logic [7:0] val,
    output logic       wrap
);
    logic at_end;

    assign at_end = (val >= max_val);
    assign wrap   = inc && !ld && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   val <= RST_VAL;
        else if (ld)  val <= ld_val;
        else if (inc) val <= at_end ? MIN_VAL : bcd_inc(val);
    end

    AST_FLD_UNITS: assert property (@(posedge clk) disable iff (!rst_n)
        val[3:0] <= 4'd9); // R2

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int DIV = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    input  logic              snap_req,
    output logic [7:0]        rd_data
);
    localparam logic [NUM_FIELDS:0][7:0] SNAP_RST =
        {8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00};

    rtc_state_e st_q, st_d;

    logic [NUM_FIELDS-1:0][7:0] time_q;
    logic [NUM_FIELDS-1:0][7:0] stg_q;
    logic [NUM_FIELDS:0][7:0]   snap_q;

    logic wr_ok, tick, run_tick, ld_go;
    logic leap_w;
    logic [7:0] dim_w;
    logic c_sec, c_min, c_hour, c_date, c_mon;
    logic unused_dow_wrap, unused_year_wrap;

    assign wr_ok = wr_en && (addr < ADDR_W'(NUM_FIELDS));

    rtc_prescaler #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (wr_ok),
        .tick (tick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // next state and strobes
    always_comb begin
        st_d  = st_q;
        ld_go = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                if (wr_ok) st_d = ST_STAGED;
            end
            ST_STAGED: begin
                if (tick) begin
                    st_d  = ST_RUN;
                    ld_go = 1'b1;
                end
            end
        endcase
    end

    assign run_tick = tick && (st_q == ST_RUN);
    assign leap_w   = is_leap(time_q[IX_YEAR]);
    assign dim_w    = month_days(time_q[IX_MON], leap_w);

    rtc_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00)) u_sec (
        .clk(clk), .rst_n(rst_n), .inc(run_tick), .ld(ld_go),
        .ld_val(stg_q[IX_SEC]), .max_val(8'h59),
        .val(time_q[IX_SEC]), .wrap(c_sec));

    rtc_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00)) u_min (
        .clk(clk), .rst_n(rst_n), .inc(c_sec), .ld(ld_go),
        .ld_val(stg_q[IX_MIN]), .max_val(8'h59),
        .val(time_q[IX_MIN]), .wrap(c_min));

    rtc_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00)) u_hour (
        .clk(clk), .rst_n(rst_n), .inc(c_min), .ld(ld_go),
        .ld_val(stg_q[IX_HOUR]), .max_val(8'h23),
        .val(time_q[IX_HOUR]), .wrap(c_hour));

    rtc_field #(.RST_VAL(8'h01), .MIN_VAL(8'h01)) u_date (
        .clk(clk), .rst_n(rst_n), .inc(c_hour), .ld(ld_go),
        .ld_val(stg_q[IX_DATE]), .max_val(dim_w),
        .val(time_q[IX_DATE]), .wrap(c_date));

    rtc_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00)) u_dow (
        .clk(clk), .rst_n(rst_n), .inc(c_hour), .ld(ld_go),
        .ld_val(stg_q[IX_DOW]), .max_val(8'h06),
        .val(time_q[IX_DOW]), .wrap(unused_dow_wrap));

    rtc_field #(.RST_VAL(8'h01), .MIN_VAL(8'h01)) u_mon (
        .clk(clk), .rst_n(rst_n), .inc(c_date), .ld(ld_go),
        .ld_val(stg_q[IX_MON]), .max_val(8'h12),
        .val(time_q[IX_MON]), .wrap(c_mon));

    rtc_field #(.RST_VAL(8'h00), .MIN_VAL(8'h00)) u_year (
        .clk(clk), .rst_n(rst_n), .inc(c_mon), .ld(ld_go),
        .ld_val(stg_q[IX_YEAR]), .max_val(8'h99),
        .val(time_q[IX_YEAR]), .wrap(unused_year_wrap));

    // staging bank: first write of a batch copies the live time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else if (wr_ok) begin
            for (int k = 0; k < NUM_FIELDS; k++) begin
                if (addr == ADDR_W'(k))     stg_q[k] <= wr_data;
                else if (st_q == ST_RUN)    stg_q[k] <= time_q[k];
            end
        end
    end

    // snapshot bank, entry NUM_FIELDS stays zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        snap_q <= SNAP_RST;
        else if (snap_req) snap_q <= {8'h00, time_q};
    end

    assign rd_data = snap_q[addr];

    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(time_q)); // R9
    AST_LOAD_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STAGED && tick) |=> (st_q == ST_RUN && time_q == $past(stg_q))); // R9
    AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && wr_en && !wr_ok) |=> (st_q == ST_RUN)); // R10
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(snap_q)); // R8
    AST_DATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (time_q[IX_DATE] != 8'h00) && (time_q[IX_DATE] <= dim_w)); // R5
    AST_DOW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        time_q[IX_DOW] <= 8'h06); // R4
    AST_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (run_tick && time_q[IX_HOUR:IX_SEC] == 24'h235959)
        |=> (time_q[IX_HOUR:IX_SEC] == 24'h000000)); // R3

endmodule

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic       snap_req = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rtc_calendar #(.DIV(DIV)) i_rtc_calendar (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .snap_req(snap_req), .rd_data(rd_data)
    );

    // ---------------- behavioural reference model ----------------
    int m_pre;
    int m_pend;
    int m_live [0:6];
    int m_stg  [0:6];
    int m_snap [0:6];

    function automatic int to_dec(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] to_bcd(input int d);
        return {4'(d / 10), 4'(d % 10)};
    endfunction

    function automatic int days_of(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_pre = 0;
        m_pend = 0;
        for (int i = 0; i < 7; i++) begin
            m_live[i] = (i == 3 || i == 5) ? 1 : 0;
            m_snap[i] = m_live[i];
            m_stg[i]  = 0;
        end
    endtask

    task automatic model_advance();
        m_live[0]++;
        if (m_live[0] == 60) begin
            m_live[0] = 0;
            m_live[1]++;
            if (m_live[1] == 60) begin
                m_live[1] = 0;
                m_live[2]++;
                if (m_live[2] == 24) begin
                    m_live[2] = 0;
                    m_live[4] = (m_live[4] + 1) % 7;
                    m_live[3]++;
                    if (m_live[3] > days_of(m_live[5], m_live[6])) begin
                        m_live[3] = 1;
                        m_live[5]++;
                        if (m_live[5] == 13) begin
                            m_live[5] = 1;
                            m_live[6] = (m_live[6] + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            if (snap_req)
                for (int i = 0; i < 7; i++) m_snap[i] = m_live[i];
            if (wr_en && addr < 3'd7) begin
                if (!m_pend)
                    for (int i = 0; i < 7; i++) m_stg[i] = m_live[i];
                m_stg[addr] = to_dec(wr_data);
                m_pend = 1;
                m_pre = 0;
            end else if (m_pre == DIV - 1) begin
                m_pre = 0;
                if (m_pend) begin
                    for (int i = 0; i < 7; i++) m_live[i] = m_stg[i];
                    m_pend = 0;
                end else begin
                    model_advance();
                end
            end else begin
                m_pre++;
            end
        end
    end

    // compare read data with the model on every clock, mid high phase
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            logic [7:0] exp_rd;
            exp_rd = (addr == 3'd7) ? 8'h00 : to_bcd(m_snap[addr]);
            checks++;
            if (rd_data !== exp_rd) begin
                fails++;
                $display("FAIL R2 model compare addr=%0d actual=%h expected=%h", addr, rd_data, exp_rd);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_field(input int a, input logic [7:0] exp, input string tag);
        addr = 3'(a);
        #1;
        check8(tag, rd_data, exp);
    endtask

    // entered and left at a falling edge
    task automatic write_reg(input int a, input logic [7:0] d);
        wr_en = 1'b1;
        addr = 3'(a);
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic take_snap();
        snap_req = 1'b1;
        @(negedge clk);
        snap_req = 1'b0;
    endtask

    task automatic wait_ticks(input int k);
        repeat (4 + DIV * k) @(negedge clk);
    endtask

    task automatic load_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                             input logic [7:0] dt, input logic [7:0] dw, input logic [7:0] mo,
                             input logic [7:0] y);
        write_reg(0, s);
        write_reg(1, mi);
        write_reg(2, h);
        write_reg(3, dt);
        write_reg(4, dw);
        write_reg(5, mo);
        write_reg(6, y);
    endtask

    task automatic check_all(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                             input logic [7:0] dt, input logic [7:0] dw, input logic [7:0] mo,
                             input logic [7:0] y, input string tag);
        take_snap();
        read_field(0, s,  {tag, " sec"});
        read_field(1, mi, {tag, " min"});
        read_field(2, h,  {tag, " hour"});
        read_field(3, dt, {tag, " date"});
        read_field(4, dw, {tag, " dow"});
        read_field(5, mo, {tag, " month"});
        read_field(6, y,  {tag, " year"});
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        check_all(8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00, "R1 reset");

        // R9: staged seconds not visible before the tick, then applied
        write_reg(0, 8'h30);
        take_snap();
        read_field(0, 8'h00, "R9 staged hidden");
        repeat (3) @(negedge clk);
        take_snap();
        read_field(0, 8'h30, "R9 staged applied");
        read_field(3, 8'h01, "R9 unwritten kept");
        @(negedge clk);

        // R3 R4 R6: midnight rollover, non-leap February
        load_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h06, 8'h02, 8'h23);
        wait_ticks(1);
        check_all(8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h03, 8'h23, "R3 R4 R6 feb non-leap");

        // R6: leap year February 28 to 29
        load_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h02, 8'h24);
        wait_ticks(1);
        check_all(8'h00, 8'h00, 8'h00, 8'h29, 8'h03, 8'h02, 8'h24, "R6 leap 24");

        // R6: year 00 is leap
        load_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h05, 8'h02, 8'h00);
        wait_ticks(1);
        check_all(8'h00, 8'h00, 8'h00, 8'h29, 8'h06, 8'h02, 8'h00, "R6 leap 00");

        // R6: leap February 29 ends the month
        load_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h01, 8'h02, 8'h24);
        wait_ticks(1);
        check_all(8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h03, 8'h24, "R6 feb29 end");

        // R5: thirty-day month
        load_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h03, 8'h04, 8'h31);
        wait_ticks(1);
        check_all(8'h00, 8'h00, 8'h00, 8'h01, 8'h04, 8'h05, 8'h31, "R5 april");

        // R5: thirty-one-day month passes day 30
        load_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h03, 8'h01, 8'h31);
        wait_ticks(1);
        check_all(8'h00, 8'h00, 8'h00, 8'h31, 8'h04, 8'h01, 8'h31, "R5 jan30");

        // R7: year end and century
        load_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h03, 8'h12, 8'h99);
        wait_ticks(1);
        check_all(8'h00, 8'h00, 8'h00, 8'h01, 8'h04, 8'h01, 8'h00, "R7 century");

        // R10: address 7 write neither stages nor restarts the prescaler
        load_time(8'h00, 8'h00, 8'h12, 8'h15, 8'h02, 8'h06, 8'h30);
        repeat (4) @(negedge clk);
        write_reg(7, 8'h55);
        repeat (3) @(negedge clk);
        take_snap();
        read_field(0, 8'h01, "R10 no restart");
        read_field(2, 8'h12, "R10 hour kept");
        read_field(7, 8'h00, "R10 addr7 reads zero");

        // R8: snapshot holds while the live time moves on
        repeat (12) @(negedge clk);
        read_field(0, 8'h01, "R8 snapshot held");
        @(negedge clk);

        // R11 R2: continuous snapshots do not drop ticks
        load_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00);
        snap_req = 1'b1;
        wait_ticks(5);
        snap_req = 1'b0;
        take_snap();
        read_field(0, 8'h05, "R11 R2 five ticks");
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule